// File: doc/BRIEF.md
# Interrupt CPU Interface with Preemption

This block connects one processor to an interrupt distributor. The distributor presents a single candidate: a valid flag, an interrupt ID and a 4-bit priority, where 0 is the most urgent level. The block raises the processor's interrupt line when three conditions hold. The interface must be enabled. The candidate must be more urgent than a programmable priority mask. The candidate must also be allowed to preempt whatever is already running, under a programmable binary point.

Software uses a small register bus. Reading the acknowledge register claims the candidate, and writing its ID to the completion register retires it. Priorities of nested, active interrupts are held on a 4-entry stack, and the top of that stack is the running priority. Each acknowledge and each completion sends a one-cycle pulse with the ID back to the distributor.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset the registers read as follows. Control (offset 0x00) reads 0. Mask (0x04) reads 0. Binary point (0x08) reads 3. Running priority (0x14) reads 0xF0. Control keeps only bit 0. Mask keeps only its 4-bit value, which it returns in bits [7:4]. Binary point keeps only bits [2:0]. All other bits read as zero.
- R2: While control bit 0 is 0, the interrupt line stays low and an acknowledge read (0x0C) returns 1023.
- R3: The interrupt line is high only when the candidate priority is numerically below the mask. A mask of 0 blocks every level, and a mask of 0xF blocks only level 0xF.
- R4: When nothing is active, any valid, unmasked candidate raises the line, whatever the binary point.
- R5: An acknowledge read of an eligible candidate returns its ID in [9:0] and pushes its priority. The running priority (0x14, bits [7:4]) then becomes that priority. One cycle after the read, ack_pulse is high for one cycle with ack_id equal to the ID.
- R6: While an interrupt is active, a candidate preempts it only if (prio >> s) < (running >> s). The shift s is 1, 2 or 3 for binary point 4, 5 or 6, and 0 for binary point 3 and for the unlisted values 0 to 2.
- R7: With binary point 7, no candidate is signalled while any interrupt is active.
- R8: The stack holds 4 active priorities. When it is full, the line stays low.
- R9: A write to end of interrupt (0x10) pops the stack, so the running priority returns to the level below. With an empty stack the write leaves the running priority at 0xF.
- R10: One cycle after each end-of-interrupt write, eoi_pulse is high for one cycle with eoi_id equal to the written bits [9:0].
- R11: The highest-pending register (0x18) returns the candidate ID when the candidate is valid and 1023 otherwise, regardless of mask or enable.
- R12: An acknowledge read when the line is low returns 1023. It pushes nothing and gives no ack_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pend_valid | input | 1 | Distributor has a candidate |
| pend_id | input | 10 | Candidate interrupt ID |
| pend_prio | input | 4 | Candidate priority, 0 most urgent |
| cpu_irq | output | 1 | Interrupt request to the processor |
| ack_pulse | output | 1 | One-cycle acknowledge notice |
| ack_id | output | 10 | ID that was acknowledged |
| eoi_pulse | output | 1 | One-cycle completion notice |
| eoi_id | output | 10 | ID that was completed |

## Verification
The bench sweeps every mask against every candidate level, which would catch an off-by-one such as using <= instead of <. It also sweeps every binary-point value against every active and candidate pair. A wrong group shift, or an unlisted value that is not folded to 3, would flip preemption results in that sweep. The stack is filled to its depth and then unwound one level at a time. A stack that overflows, or that fails to restore the level below, would show a wrong running priority or a line raised while full. An acknowledge that is masked or blocked must return 1023 without disturbing the stack.

// File: rtl/irq_cpu_if.sv
module irq_cpu_if #(
  parameter int ID_W   = 10,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pend_valid,
  input  logic [ID_W-1:0]   pend_id,
  input  logic [3:0]        pend_prio,
  output logic              cpu_irq,
  output logic              ack_pulse,
  output logic [ID_W-1:0]   ack_id,
  output logic              eoi_pulse,
  output logic [ID_W-1:0]   eoi_id
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ID_W-1:0] SPURIOUS = '1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_BPT  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(5'h14);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(5'h18);

  logic             en;
  logic [3:0]       pmask;
  logic [2:0]       bpt;
  logic [3:0]       stk [DEPTH];
  logic [CNT_W-1:0] depth;
  logic [3:0]       run_prio;
  logic [2:0]       sh;
  logic             preempt_ok;

  assign run_prio = (depth == '0) ? 4'hF : stk[IDX_W'(depth - 1'b1)];
  assign sh = (bpt >= 3'd4 && bpt <= 3'd6) ? bpt - 3'd3 : 3'd0;
  assign preempt_ok = (depth == '0) ||
                      (bpt != 3'd7 && (pend_prio >> sh) < (run_prio >> sh));
  assign cpu_irq = en && pend_valid && (pend_prio < pmask) &&
                   (depth < CNT_W'(DEPTH)) && preempt_ok;

  wire ack_rd = bus_sel && !bus_wr && bus_addr == A_ACK;
  wire eoi_wr = bus_sel &&  bus_wr && bus_addr == A_EOI;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_CTRL: bus_rdata[0]   = en;
        A_MASK: bus_rdata[7:4] = pmask;
        A_BPT:  bus_rdata[2:0] = bpt;
        A_ACK:  bus_rdata[ID_W-1:0] = cpu_irq ? pend_id : SPURIOUS;
        A_RUN:  bus_rdata[7:4] = run_prio;
        A_HIGH: bus_rdata[ID_W-1:0] = pend_valid ? pend_id : SPURIOUS;
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      pmask     <= 4'h0;
      bpt       <= 3'd3;
      depth     <= '0;
      ack_pulse <= 1'b0;
      ack_id    <= '0;
      eoi_pulse <= 1'b0;
      eoi_id    <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= 4'hF;
    end else begin
      ack_pulse <= ack_rd && cpu_irq;
      eoi_pulse <= eoi_wr;
      if (ack_rd && cpu_irq) begin
        ack_id <= pend_id;
        stk[IDX_W'(depth)] <= pend_prio;
        depth <= depth + 1'b1;
      end
      if (eoi_wr) begin
        eoi_id <= bus_wdata[ID_W-1:0];
        if (depth != '0) depth <= depth - 1'b1;
      end
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          A_CTRL: en    <= bus_wdata[0];
          A_MASK: pmask <= bus_wdata[7:4];
          A_BPT:  bpt   <= bus_wdata[2:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_cpu_if_chk.sv
module irq_cpu_if_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              en,
  input logic [3:0]        pmask,
  input logic [2:0]        bpt,
  input logic [3:0]        pend_prio,
  input logic [CNT_W-1:0]  depth,
  input logic              cpu_irq,
  input logic              ack_pulse,
  input logic              eoi_pulse
);
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !cpu_irq);
  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> pend_prio < pmask);
  assert_ack_follows_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> $past(cpu_irq) && depth == $past(depth) + 1'b1);
  assert_no_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bpt == 3'd7 && depth != '0) |-> !cpu_irq);
  assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH) && (depth == CNT_W'(DEPTH) -> !cpu_irq));
  assert_eoi_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pulse && $past(depth) != '0) |-> depth == $past(depth) - 1'b1);
  assert_eoi_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(5'h10)));
endmodule

bind irq_cpu_if irq_cpu_if_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .en(en), .pmask(pmask), .bpt(bpt),
  .pend_prio(pend_prio), .depth(depth), .cpu_irq(cpu_irq),
  .ack_pulse(ack_pulse), .eoi_pulse(eoi_pulse)
);

// File: tb/irq_cpu_if_tb_top.sv
module irq_cpu_if_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        pend_valid = 0;
  logic [9:0]  pend_id = '0;
  logic [3:0]  pend_prio = '0;
  logic        cpu_irq, ack_pulse, eoi_pulse;
  logic [9:0]  ack_id, eoi_id;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] d;

  always #2 clk = ~clk;

  irq_cpu_if dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_valid(pend_valid), .pend_id(pend_id), .pend_prio(pend_prio),
    .cpu_irq(cpu_irq), .ack_pulse(ack_pulse), .ack_id(ack_id),
    .eoi_pulse(eoi_pulse), .eoi_id(eoi_id));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] data);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 data = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic set_pend(input logic v, input logic [9:0] id, input logic [3:0] p);
    pend_valid = v; pend_id = id; pend_prio = p; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(5'h00, d); check("R1 ctrl reset", d, 0);
    rd(5'h04, d); check("R1 mask reset", d, 0);
    rd(5'h08, d); check("R1 bpt reset", d, 3);
    rd(5'h14, d); check("R1 running reset", d, 32'hF0);
    rd(5'h18, d); check("R11 high empty", d, 1023);
    check("R1 irq reset", cpu_irq, 0);
    // R1 reserved bits
    wr(5'h00, 32'hFFFF_FFFE); rd(5'h00, d); check("R1 ctrl reserved", d, 0);
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); check("R1 mask field", d, 32'hF0);
    wr(5'h08, 32'hFFFF_FFFD); rd(5'h08, d); check("R1 bpt field", d, 5);
    // R2 disabled
    set_pend(1, 10'd33, 4'h0);
    check("R2 irq disabled", cpu_irq, 0);
    rd(5'h0C, d); check("R2 ack disabled", d, 1023);
    check("R12 no pulse disabled", ack_pulse, 0);
    wr(5'h00, 1); rd(5'h00, d); check("R1 ctrl enable", d, 1);
    // R3 exhaustive mask sweep
    for (int m = 0; m < 16; m++) begin
      wr(5'h04, m << 4);
      for (int p = 0; p < 16; p++) begin
        set_pend(1, 10'd40, 4'(p));
        check($sformatf("R3 m=%0d p=%0d", m, p), cpu_irq, (p < m));
      end
    end
    // R4 nothing active, any bpt
    wr(5'h04, 32'hF0);
    for (int b = 0; b < 8; b++) begin
      wr(5'h08, b);
      set_pend(1, 10'd41, 4'hE);
      check($sformatf("R4 bpt=%0d", b), cpu_irq, 1);
    end
    // R11 high pending vs masked ack (R12)
    wr(5'h04, 0);
    set_pend(1, 10'd50, 4'h3);
    rd(5'h18, d); check("R11 high valid", d, 50);
    rd(5'h0C, d); check("R12 masked ack", d, 1023);
    check("R12 masked no pulse", ack_pulse, 0);
    rd(5'h14, d); check("R12 no push", d, 32'hF0);
    set_pend(0, 10'd50, 4'h3);
    rd(5'h18, d); check("R11 high invalid", d, 1023);
    wr(5'h04, 32'hF0);
    // R5 acknowledge
    wr(5'h08, 3);
    set_pend(1, 10'd40, 4'h4);
    rd(5'h0C, d); check("R5 ack id", d, 40);
    check("R5 ack pulse", ack_pulse, 1);
    check("R5 ack_id", ack_id, 40);
    @(negedge clk); check("R5 pulse one cycle", ack_pulse, 0);
    rd(5'h14, d); check("R5 running", d, 32'h40);
    wr(5'h10, 40);
    // R6 R7 preemption sweep
    for (int b = 0; b < 8; b++) begin
      int sh;
      sh = (b >= 4 && b <= 6) ? b - 3 : 0;
      wr(5'h08, b);
      for (int a = 0; a < 15; a++) begin
        set_pend(1, 10'd100, 4'(a));
        rd(5'h0C, d);
        for (int p = 0; p < 16; p++) begin
          bit exp;
          exp = (p < 15) && (b != 7) && ((p >> sh) < (a >> sh));
          set_pend(1, 10'd101, 4'(p));
          check($sformatf("%s b=%0d a=%0d p=%0d", (b == 7) ? "R7" : "R6", b, a, p),
                cpu_irq, exp);
        end
        wr(5'h10, 100);
      end
    end
    // R6 grouping example: bp 5, active 6, pending 4 blocked, pending 0 preempts
    wr(5'h08, 5);
    set_pend(1, 10'd60, 4'h6); rd(5'h0C, d);
    set_pend(1, 10'd61, 4'h4); check("R6 same group blocked", cpu_irq, 0);
    set_pend(1, 10'd62, 4'h0); check("R6 urgent preempts", cpu_irq, 1);
    wr(5'h10, 60);
    // R8 R9 stack fill and unwind
    wr(5'h08, 3);
    for (int k = 0; k < 4; k++) begin
      set_pend(1, 10'(70 + k), 4'(8 - 2 * k));
      rd(5'h0C, d); check($sformatf("R8 push %0d", k), d, 70 + k);
    end
    rd(5'h14, d); check("R8 running top", d, 32'h20);
    set_pend(1, 10'd80, 4'h0);
    check("R8 full blocks", cpu_irq, 0);
    rd(5'h0C, d); check("R12 full ack", d, 1023);
    check("R12 full no pulse", ack_pulse, 0);
    for (int k = 3; k >= 0; k--) begin
      wr(5'h10, 70 + k);
      check("R10 eoi pulse", eoi_pulse, 1);
      check("R10 eoi id", eoi_id, 70 + k);
      rd(5'h14, d);
      check($sformatf("R9 pop %0d", k), d, (k == 0) ? 32'hF0 : ((8 - 2 * (k - 1)) << 4));
    end
    check("R10 pulse one cycle", eoi_pulse, 0);
    wr(5'h10, 77);
    check("R10 eoi empty pulse", eoi_id, 77);
    rd(5'h14, d); check("R9 empty stays", d, 32'hF0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule